// File: doc/BRIEF.md
# Dual-Channel Event Timestamp Capture

This block freezes the value of a free-running 64-bit time counter at the moment a qualifying packet event is flagged. It has one capture slot for the receive path and one for the transmit path. Each slot holds a single captured time. It keeps that value until software writes an acknowledge to the slot's status word. While a slot is full, later events are not stored. Each one that arrives sets a sticky overflow flag instead.

Each path has its own enable input, so the transmit side can be turned off while receive capture continues. Software reads a status word holding the valid flag, the overflow flag and a capture sequence count. It then reads the held time as a low 32-bit word and a high 32-bit word, and writes the status word with bit 16 set to free the slot. Software is expected to do that acknowledge when it turns capture on and whenever the event filtering upstream is changed, so that a stale value is not mistaken for a new one.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, both status words read 0 and both time words of each channel read 0.
- R2: With the channel's enable high and its slot empty, an event strobe stores `time_now` from that same cycle. From the next cycle, status bit 16 reads 1, word 1 returns time bits 31:0 and word 2 returns time bits 63:32.
- R3: While status bit 16 is 1, further events leave the stored time unchanged.
- R4: An enabled event that arrives while the slot is full sets status bit 17. Bit 17 stays set until the slot is acknowledged.
- R5: A bus write to a channel's status word with bit 16 set clears that channel's bits 16 and 17. A write with bit 16 clear changes nothing.
- R6: While a channel's enable is low, its events are ignored: no capture, no overflow and no count change.
- R7: Status bits SEQ_W-1:0 count accepted captures, modulo 2^SEQ_W.
- R8: The two channels are independent. Address bit 2 selects the channel (0 receive, 1 transmit), and address bits 1:0 select the word (0 status, 1 low time, 2 high time).
- R9: An enabled event in the same cycle as an acknowledge write to its channel is captured.
- R10: Word 3 of each channel reads 0. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TIME_W | Live time value |
| rx_evt | input | 1 | Receive event strobe |
| rx_en | input | 1 | Receive capture enable |
| tx_evt | input | 1 | Transmit event strobe |
| tx_en | input | 1 | Transmit capture enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address {channel, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |

## Verification
A capture and an acknowledge each take effect one clock edge after the strobe or write is presented. The read data follows the address within the same cycle. The bench applies every input just after a falling edge. It reads back on the following falling edge, after exactly one rising edge, so each check lands on the first cycle a result is due. Events that must be dropped or ignored are checked by reading the status and time words right after the event, before any acknowledge can mask them.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_CH    = 2;
   localparam int CH_W      = $clog2(NUM_CH);
   localparam int ADDR_W    = CH_W + 2;
   localparam int VALID_BIT = 16;
   localparam int OVF_BIT   = 17;

   typedef enum logic [1:0] {
      W_STATUS = 2'd0,
      W_LOW    = 2'd1,
      W_HIGH   = 2'd2,
      W_RSVD   = 2'd3
   } word_sel_e;
endpackage

// File: rtl/ts_cap_slot.sv
module ts_cap_slot #(
   parameter int TIME_W = 64,
   parameter int SEQ_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              evt,
   input  logic              clr,
   input  logic [TIME_W-1:0] time_now,
   output logic              valid_o,
   output logic              ovf_o,
   output logic [SEQ_W-1:0]  seq_o,
   output logic [TIME_W-1:0] ts_o
);
   logic              valid_q, ovf_q;
   logic [SEQ_W-1:0]  seq_q;
   logic [TIME_W-1:0] ts_q;
   logic              take, drop;

   // a slot freed by acknowledge this cycle may accept the event
   assign take = en && evt && (!valid_q || clr);
   assign drop = en && evt && valid_q && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
         seq_q   <= '0;
         ts_q    <= '0;
      end else begin
         if (clr) begin
            valid_q <= take;
            ovf_q   <= 1'b0;
         end else begin
            if (take) valid_q <= 1'b1;
            if (drop) ovf_q   <= 1'b1;
         end
         if (take) begin
            ts_q  <= time_now;
            seq_q <= seq_q + 1'b1;
         end
      end
   end

   assign valid_o = valid_q;
   assign ovf_o   = ovf_q;
   assign seq_o   = seq_q;
   assign ts_o    = ts_q;
endmodule

// File: rtl/ts_cap_wrdec.sv
module ts_cap_wrdec
   import ts_cap_pkg::*;
#(
   parameter int NCH = NUM_CH
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ack_bit,
   output logic [NCH-1:0]    clr
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign clr[c] = wr && ack_bit
                      && (addr[ADDR_W-1:2] == CH_W'(c))
                      && (word_sel_e'(addr[1:0]) == W_STATUS);
   end
endmodule

// File: rtl/ts_cap_regmux.sv
module ts_cap_regmux
   import ts_cap_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int SEQ_W  = 8,
   parameter int NCH    = NUM_CH
) (
   input  logic [NCH-1:0]             valid,
   input  logic [NCH-1:0]             ovf,
   input  logic [NCH-1:0][SEQ_W-1:0]  seq,
   input  logic [NCH-1:0][TIME_W-1:0] ts,
   input  logic [ADDR_W-1:0]          addr,
   output logic [WORD_W-1:0]          rdata
);
   logic [CH_W-1:0]   sel;
   logic [WORD_W-1:0] status_w, low_w, high_w;
   logic [TIME_W-1:0] ts_sel;

   assign sel    = addr[ADDR_W-1:2];
   assign ts_sel = ts[sel];
   assign low_w  = ts_sel[WORD_W-1:0];

   // upper word: full width or zero-padded when the time is narrower
   if (TIME_W == 2*WORD_W) begin : g_high_full
      assign high_w = ts_sel[TIME_W-1:WORD_W];
   end else begin : g_high_pad
      assign high_w = {{(2*WORD_W-TIME_W){1'b0}}, ts_sel[TIME_W-1:WORD_W]};
   end

   always_comb begin
      status_w                = '0;
      status_w[SEQ_W-1:0]     = seq[sel];
      status_w[VALID_BIT]     = valid[sel];
      status_w[OVF_BIT]       = ovf[sel];
   end

   always_comb begin
      unique case (word_sel_e'(addr[1:0]))
         W_STATUS: rdata = status_w;
         W_LOW:    rdata = low_w;
         W_HIGH:   rdata = high_w;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ts_capture_pair.sv
module ts_capture_pair
   import ts_cap_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int SEQ_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic              rx_evt,
   input  logic              rx_en,
   input  logic              tx_evt,
   input  logic              tx_en,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   if (TIME_W < WORD_W + 1 || TIME_W > 2*WORD_W) begin : g_bad_time
      $error("ts_capture_pair: TIME_W must lie in 33..64");
   end
   if (SEQ_W < 1 || SEQ_W > VALID_BIT) begin : g_bad_seq
      $error("ts_capture_pair: SEQ_W must lie in 1..16");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("ts_capture_pair: address width mismatch");
   end

   logic [NUM_CH-1:0]             ch_evt, ch_en, ch_clr, ch_valid, ch_ovf;
   logic [NUM_CH-1:0][SEQ_W-1:0]  ch_seq;
   logic [NUM_CH-1:0][TIME_W-1:0] ch_ts;
   logic                          unused_wdata;

   assign ch_evt       = {tx_evt, rx_evt};
   assign ch_en        = {tx_en, rx_en};
   assign unused_wdata = ^{reg_wdata[31:VALID_BIT+1], reg_wdata[VALID_BIT-1:0]};

   ts_cap_wrdec #(.NCH(NUM_CH)) u_wrdec (
      .wr      (reg_wr),
      .addr    (reg_addr),
      .ack_bit (reg_wdata[VALID_BIT]),
      .clr     (ch_clr)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      ts_cap_slot #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (ch_en[c]),
         .evt      (ch_evt[c]),
         .clr      (ch_clr[c]),
         .time_now (time_now),
         .valid_o  (ch_valid[c]),
         .ovf_o    (ch_ovf[c]),
         .seq_o    (ch_seq[c]),
         .ts_o     (ch_ts[c])
      );
   end

   ts_cap_regmux #(.TIME_W(TIME_W), .SEQ_W(SEQ_W), .NCH(NUM_CH)) u_mux (
      .valid (ch_valid),
      .ovf   (ch_ovf),
      .seq   (ch_seq),
      .ts    (ch_ts),
      .addr  (reg_addr),
      .rdata (reg_rdata)
   );
endmodule

// File: rtl/ts_capture_pair_chk.sv
module ts_capture_pair_chk #(
   parameter int TIME_W = 64,
   parameter int SEQ_W  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TIME_W-1:0]     time_now,
   input logic [1:0]            ch_evt,
   input logic [1:0]            ch_en,
   input logic [1:0]            ch_clr,
   input logic [1:0]            ch_valid,
   input logic [1:0]            ch_ovf,
   input logic [1:0][SEQ_W-1:0] ch_seq,
   input logic [1:0][TIME_W-1:0] ch_ts
);
   for (genvar c = 0; c < 2; c++) begin : g_c
      assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ch_evt[c] && ch_en[c] && !ch_valid[c] && !ch_clr[c]
         |=> ch_valid[c] && ch_ts[c] == $past(time_now));
      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ch_valid[c] && !ch_clr[c] |=> ch_valid[c] && $stable(ch_ts[c]));
      assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ch_evt[c] && ch_en[c] && ch_valid[c] && !ch_clr[c] |=> ch_ovf[c]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ch_clr[c] && !(ch_evt[c] && ch_en[c]) |=> !ch_valid[c] && !ch_ovf[c]);
      assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] && !ch_clr[c]
         |=> $stable(ch_ts[c]) && $stable(ch_seq[c]) && $stable(ch_ovf[c]));
      assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ch_evt[c] && ch_en[c] && (!ch_valid[c] || ch_clr[c])
         |=> ch_seq[c] == SEQ_W'($past(ch_seq[c]) + 1'b1));
      assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ch_clr[c] && ch_evt[c] && ch_en[c]
         |=> ch_valid[c] && ch_ts[c] == $past(time_now));
   end
endmodule

bind ts_capture_pair ts_capture_pair_chk #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .time_now (time_now),
   .ch_evt   (ch_evt),
   .ch_en    (ch_en),
   .ch_clr   (ch_clr),
   .ch_valid (ch_valid),
   .ch_ovf   (ch_ovf),
   .ch_seq   (ch_seq),
   .ch_ts    (ch_ts)
);

// File: tb/ts_capture_pair_bench.sv
module ts_capture_pair_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic        rx_evt = 1'b0, rx_en = 1'b0, tx_evt = 1'b0, tx_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_run = 0, n_fail = 0;
   int rx_seq = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ts_capture_pair u_ts_capture_pair (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .rx_evt(rx_evt), .rx_en(rx_en), .tx_evt(tx_evt), .tx_en(tx_en),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input int ch, input int word, output logic [31:0] v);
      reg_addr = 3'({ch[0], word[1:0]});
      #1;
      v = reg_rdata;
   endtask

   task automatic expect_word(input string req, input int ch, input int word,
                              input logic [31:0] exp);
      logic [31:0] v;
      rd(ch, word, v);
      check(req, $sformatf("ch%0d word%0d", ch, word), v, exp);
   endtask

   // event pulse, optionally with a same-cycle acknowledge write
   task automatic pulse(input int ch, input logic [63:0] t, input bit ack);
      @(negedge clk);
      time_now = t;
      if (ch == 0) rx_evt = 1'b1; else tx_evt = 1'b1;
      if (ack) begin
         reg_wr = 1'b1; reg_addr = 3'({ch[0], 2'd0}); reg_wdata = 32'h0001_0000;
      end
      @(negedge clk);
      rx_evt = 1'b0; tx_evt = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic wr_status(input int ch, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'({ch[0], 2'd0}); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic t_reset;
      for (int ch = 0; ch < 2; ch++) begin
         for (int w = 0; w < 3; w++) expect_word("R1", ch, w, 32'h0);
         expect_word("R10", ch, 3, 32'h0);
      end
   endtask

   task automatic t_capture;
      rx_en = 1'b1;
      pulse(0, 64'h1234_5678_9ABC_DEF0, 1'b0);
      rx_seq++;
      expect_word("R2", 0, 0, 32'h0001_0001);
      expect_word("R2", 0, 1, 32'h9ABC_DEF0);
      expect_word("R2", 0, 2, 32'h1234_5678);
      expect_word("R8", 1, 0, 32'h0);
   endtask

   task automatic t_hold;
      pulse(0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
      expect_word("R3", 0, 1, 32'h9ABC_DEF0);
      expect_word("R3", 0, 2, 32'h1234_5678);
      expect_word("R4", 0, 0, 32'h0003_0001);
      pulse(0, 64'h5, 1'b0);
      expect_word("R4", 0, 0, 32'h0003_0001);
      wr_status(0, 32'h0000_FFFF);
      expect_word("R5", 0, 0, 32'h0003_0001);
      expect_word("R10", 0, 1, 32'h9ABC_DEF0);
      expect_word("R10", 0, 0, 32'h0003_0001);
   endtask

   task automatic t_clear;
      wr_status(0, 32'h0001_0000);
      expect_word("R5", 0, 0, 32'h0000_0001);
   endtask

   task automatic t_disable;
      rx_en = 1'b0;
      pulse(0, 64'h7777_0000_7777_0000, 1'b0);
      expect_word("R6", 0, 0, 32'h0000_0001);
      expect_word("R6", 0, 1, 32'h9ABC_DEF0);
      rx_en = 1'b1;
   endtask

   task automatic t_indep;
      tx_en = 1'b1;
      pulse(1, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0);
      expect_word("R8", 1, 0, 32'h0001_0001);
      expect_word("R8", 1, 1, 32'hF0F0_F0F0);
      expect_word("R8", 1, 2, 32'h0F0F_0F0F);
      expect_word("R8", 0, 0, 32'h0000_0001);
      wr_status(1, 32'h0001_0000);
      expect_word("R8", 1, 0, 32'h0000_0001);
   endtask

   task automatic t_coincide;
      pulse(0, 64'h1111_2222_3333_4444, 1'b0);
      rx_seq++;
      pulse(0, 64'h5555_6666_7777_8888, 1'b1);
      rx_seq++;
      expect_word("R9", 0, 0, 32'h0001_0000 | 32'(rx_seq % 256));
      expect_word("R9", 0, 1, 32'h7777_8888);
      expect_word("R9", 0, 2, 32'h5555_6666);
   endtask

   task automatic t_wrap;
      wr_status(0, 32'h0001_0000);
      while (rx_seq % 256 != 0) begin
         pulse(0, 64'(rx_seq), 1'b0);
         rx_seq++;
         wr_status(0, 32'h0001_0000);
      end
      expect_word("R7", 0, 0, 32'h0000_0000);
      pulse(0, 64'hABCD, 1'b0);
      expect_word("R7", 0, 0, 32'h0001_0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_capture;
      t_hold;
      t_clear;
      t_disable;
      t_indep;
      t_coincide;
      t_wrap;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule